// File: doc/BRIEF.md
# Shared-Bus Processor Datapath

This block is the data half of a small 16-bit processor. Every transfer between its parts crosses a single 16-bit bus. A 4-bit gate-enable vector picks one source for that bus. The sources are the program counter value (supplied from outside), the memory data register, the ALU result and the address-adder result (also supplied from outside). The loads are per-register enables sampled on the clock edge. They target the memory address register, the memory data register, the instruction register, the eight-entry register file and the 3-bit condition code register.

A sequencer outside the block drives one control word per cycle and reads back the instruction register and the condition codes. Register selection comes from instruction fields. The destination is IR[11:9] or the fixed register 7. The first source is IR[11:9] or IR[8:6]. The second source is IR[2:0], or a sign-extended IR[4:0] when IR[5] is set.

The memory array answers in the same cycle it is enabled. The ALU's pass mode is the only way a register value reaches the bus, for example ahead of a store.

Top module: `bus_datapath`

## Requirements
- R1: After a synchronous reset, all eight registers read zero, the instruction register is zero and the condition codes are 3'b010 (zero).
- R2: When no gate enable is active, bus_out is zero.
- R3: gate_en bit 0 drives pc_val onto the bus, bit 1 the memory data register, bit 2 the ALU result and bit 3 addr_val. At most one bit is set in any cycle.
- R4: A register is written with the bus value on a clock edge only while ld_reg is 1. With ld_reg at 0 its contents are unchanged.
- R5: With dr_sel at 0 the destination is IR[11:9]; with dr_sel at 1 it is register 7, whatever IR[11:9] holds.
- R6: With sr1_sel at 0 the first ALU operand is the register named by IR[11:9]; with sr1_sel at 1 it is the register named by IR[8:6].
- R7: alu_op 2'b00 gives A+B (16-bit wrap), 2'b01 gives A AND B, 2'b10 gives NOT A and 2'b11 passes A. B is the register named by IR[2:0] when IR[5] is 0, and sign-extended IR[4:0] when IR[5] is 1.
- R8: cc_out is {n,z,p}. When ld_cc is 1, the register loads from the bus on the clock edge: z if the bus is zero, n if bus bit 15 is set, p otherwise. Exactly one bit is set at all times. With ld_cc at 0 it holds.
- R9: With mem_en and mem_we both 1, the memory word addressed by the low ADDR_W bits of the memory address register takes the memory data register's value. A later read of that address returns it.
- R10: When ld_mdr is 1, the memory data register loads the memory word at the current address if mem_en is 1, and the bus value if mem_en is 0.
- R11: The instruction register and the memory address register load from the bus only while their load enable is 1, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 4 | Bus source enables: bit0 PC, bit1 MDR, bit2 ALU, bit3 address adder |
| ld_mar | input | 1 | Load memory address register from bus |
| ld_mdr | input | 1 | Load memory data register |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_reg | input | 1 | Write destination register from bus |
| ld_cc | input | 1 | Load condition codes from bus |
| dr_sel | input | 1 | Destination select: 0 IR[11:9], 1 register 7 |
| sr1_sel | input | 1 | First source select: 0 IR[11:9], 1 IR[8:6] |
| alu_op | input | 2 | ALU operation code |
| mem_en | input | 1 | Memory access enable |
| mem_we | input | 1 | 1 write, 0 read |
| pc_val | input | 16 | Program counter value from the address block |
| addr_val | input | 16 | Address adder result from the address block |
| bus_out | output | 16 | Current bus value |
| ir_out | output | 16 | Instruction register |
| cc_out | output | 3 | Condition codes {n,z,p} |
| sr1_out | output | 16 | First source register value, used as a base by the address block |

## Verification
A wrong register, MDR or memory word is invisible until a later cycle gates that value onto the bus. The bench therefore reads back through the ALU pass mode or the MDR gate, one or two cycles after the write. A wrong condition code shows on cc_out in the cycle after the load. A wrong operand selection or ALU operation corrupts bus_out in the same cycle it is exercised.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_AND  = 2'b01,
    ALU_NOT  = 2'b10,
    ALU_PASS = 2'b11
  } alu_op_e;

  localparam int GATE_PC  = 0;
  localparam int GATE_MDR = 1;
  localparam int GATE_ALU = 2;
  localparam int GATE_ADR = 3;
  localparam int GATE_CNT = 4;

  localparam int RSEL_W = 3;
  localparam logic [RSEL_W-1:0] LINK_REG = 3'd7;
endpackage

// File: rtl/dp_bus.sv
module dp_bus #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]      bus
);
  logic [N:0][W-1:0] acc;
  assign acc[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_merge
    assign acc[g+1] = acc[g] | (src[g] & {W{en[g]}});
  end

  assign bus = acc[N];

  assert_single_driver_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en));
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(wa)] == $past(wd));
  assert_read_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    (we && ra1 == wa) |=> (ra1 != $past(wa)) || (rd1 == $past(wd)));
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 16
) (
  input  logic           [W-1:0] a,
  input  logic           [W-1:0] b_reg,
  input  logic           [5:0]   imm_field,
  input  dp_pkg::alu_op_e        op,
  output logic           [W-1:0] y
);
  import dp_pkg::*;
  logic [W-1:0] b;

  assign b = imm_field[5] ? {{(W-5){imm_field[4]}}, imm_field[4:0]} : b_reg;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_AND:  y = a & b;
      ALU_NOT:  y = ~a;
      default:  y = a;
    endcase
  end
endmodule

// File: rtl/dp_cc.sv
module dp_cc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] bus,
  output logic [2:0]   cc
);
  logic [2:0] next_cc;

  always_comb begin
    if (bus == '0)       next_cc = 3'b010;
    else if (bus[W-1])   next_cc = 3'b100;
    else                 next_cc = 3'b001;
  end

  always_ff @(posedge clk) begin
    if (rst)     cc <= 3'b010;
    else if (ld) cc <= next_cc;
  end

  assert_cc_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot(cc));
  assert_cc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(cc));
  assert_cc_sign_R8: assert property (@(posedge clk) disable iff (rst)
    (ld && bus[W-1]) |=> cc == 3'b100);
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int W  = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  assert_store_lands_R9: assert property (@(posedge clk)
    (en && we) |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath #(
  parameter int DATA_W = 16,
  parameter int REG_N  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        gate_en,
  input  logic              ld_mar,
  input  logic              ld_mdr,
  input  logic              ld_ir,
  input  logic              ld_reg,
  input  logic              ld_cc,
  input  logic              dr_sel,
  input  logic              sr1_sel,
  input  logic [1:0]        alu_op,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] addr_val,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] ir_out,
  output logic [2:0]        cc_out,
  output logic [DATA_W-1:0] sr1_out
);
  import dp_pkg::*;
  localparam int RW = $clog2(REG_N);

  logic [DATA_W-1:0] bus, ir, mar, mdr, alu_y, rd2, mem_rdata;
  logic [RW-1:0]     dr, sr1, sr2;
  logic [GATE_CNT-1:0][DATA_W-1:0] srcs;
  logic unused_mar_hi;

  assign dr  = dr_sel  ? RW'(LINK_REG) : RW'(ir[11:9]);
  assign sr1 = sr1_sel ? RW'(ir[8:6])  : RW'(ir[11:9]);
  assign sr2 = RW'(ir[2:0]);

  assign srcs[GATE_PC]  = pc_val;
  assign srcs[GATE_MDR] = mdr;
  assign srcs[GATE_ALU] = alu_y;
  assign srcs[GATE_ADR] = addr_val;

  dp_bus #(.W(DATA_W), .N(GATE_CNT)) u_bus (
    .clk(clk), .rst(rst), .en(gate_en), .src(srcs), .bus(bus)
  );

  dp_regfile #(.W(DATA_W), .DEPTH(REG_N)) u_rf (
    .clk(clk), .rst(rst), .we(ld_reg), .wa(dr), .wd(bus),
    .ra1(sr1), .ra2(sr2), .rd1(sr1_out), .rd2(rd2)
  );

  dp_alu #(.W(DATA_W)) u_alu (
    .a(sr1_out), .b_reg(rd2), .imm_field(ir[5:0]),
    .op(alu_op_e'(alu_op)), .y(alu_y)
  );

  dp_cc #(.W(DATA_W)) u_cc (
    .clk(clk), .rst(rst), .ld(ld_cc), .bus(bus), .cc(cc_out)
  );

  dp_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mar[ADDR_W-1:0]),
    .wdata(mdr), .rdata(mem_rdata)
  );

  assign unused_mar_hi = ^mar[DATA_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
    end else begin
      if (ld_ir)  ir  <= bus;
      if (ld_mar) mar <= bus;
      if (ld_mdr) mdr <= mem_en ? mem_rdata : bus;
    end
  end

  assign bus_out = bus;
  assign ir_out  = ir;

  assert_mdr_from_mem_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_mdr && mem_en) |=> mdr == $past(mem_rdata));
  assert_mdr_from_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_mdr && !mem_en) |=> mdr == $past(bus));
  assert_ir_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ld_ir |=> $stable(ir));
  assert_mar_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ld_mar |=> $stable(mar));
endmodule

// File: tb/bus_datapath_tb.sv
`timescale 1ns/1ps
module bus_datapath_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] gate_en = '0;
  logic ld_mar = 0, ld_mdr = 0, ld_ir = 0, ld_reg = 0, ld_cc = 0;
  logic dr_sel = 0, sr1_sel = 0, mem_en = 0, mem_we = 0;
  logic [1:0] alu_op = '0;
  logic [15:0] pc_val = '0, addr_val = '0;
  logic [15:0] bus_out, ir_out, sr1_out;
  logic [2:0]  cc_out;

  always #4 clk = ~clk;

  bus_datapath u_dut (
    .clk(clk), .rst(rst), .gate_en(gate_en), .ld_mar(ld_mar), .ld_mdr(ld_mdr),
    .ld_ir(ld_ir), .ld_reg(ld_reg), .ld_cc(ld_cc), .dr_sel(dr_sel),
    .sr1_sel(sr1_sel), .alu_op(alu_op), .mem_en(mem_en), .mem_we(mem_we),
    .pc_val(pc_val), .addr_val(addr_val), .bus_out(bus_out), .ir_out(ir_out),
    .cc_out(cc_out), .sr1_out(sr1_out)
  );

  typedef struct packed {
    logic [3:0] gate;
    logic mar, mdr, ir, rg, cc, drs, s1s, men, mwe;
    logic [1:0] op;
    logic [15:0] pcv, adv;
  } ctl_t;

  typedef struct {
    bit cb; logic [15:0] eb;
    bit cc; logic [2:0]  ec;
    bit ci; logic [15:0] ei;
    string tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic ctl_t idle();
    return '0;
  endfunction

  function automatic item_t mk(bit cb, logic [15:0] eb, bit cc, logic [2:0] ec,
                               bit ci, logic [15:0] ei, string tag);
    item_t it;
    it.cb = cb; it.eb = eb; it.cc = cc; it.ec = ec; it.ci = ci; it.ei = ei; it.tag = tag;
    return it;
  endfunction

  task automatic step(input ctl_t c, input item_t it);
    @(negedge clk);
    gate_en = c.gate; ld_mar = c.mar; ld_mdr = c.mdr; ld_ir = c.ir;
    ld_reg = c.rg; ld_cc = c.cc; dr_sel = c.drs; sr1_sel = c.s1s;
    mem_en = c.men; mem_we = c.mwe; alu_op = c.op; pc_val = c.pcv; addr_val = c.adv;
    q.push_back(it);
  endtask

  // Monitor: compares what the scoreboard expects for each driven cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.cb) begin
          n_chk++;
          if (bus_out !== it.eb) begin
            n_fail++;
            $display("FAIL %s bus got %h expected %h", it.tag, bus_out, it.eb);
          end
        end
        if (it.cc) begin
          n_chk++;
          if (cc_out !== it.ec) begin
            n_fail++;
            $display("FAIL %s cc got %b expected %b", it.tag, cc_out, it.ec);
          end
        end
        if (it.ci) begin
          n_chk++;
          if (ir_out !== it.ei) begin
            n_fail++;
            $display("FAIL %s ir got %h expected %h", it.tag, ir_out, it.ei);
          end
        end
      end
    end
  end

  task automatic put_ir(input logic [15:0] v);
    ctl_t c = idle();
    c.gate = 4'b0001; c.pcv = v; c.ir = 1;
    step(c, mk(1, v, 0, 0, 0, 0, "R3"));
  endtask

  task automatic put_reg(input logic [2:0] r, input logic [15:0] v, input bit with_cc);
    ctl_t c = idle();
    put_ir({4'h1, r, 9'h0});
    c.gate = 4'b0001; c.pcv = v; c.rg = 1; c.cc = with_cc;
    step(c, mk(1, v, 0, 0, 1, {4'h1, r, 9'h0}, "R11"));
  endtask

  task automatic get_reg(input logic [2:0] r, input logic [15:0] exp, input string tag);
    ctl_t c = idle();
    put_ir({4'h0, 3'd0, r, 6'd0});
    c.gate = 4'b0100; c.op = 2'b11; c.s1s = 1;
    step(c, mk(1, exp, 0, 0, 0, 0, tag));
  endtask

  task automatic peek_cc(input logic [2:0] exp, input string tag);
    step(idle(), mk(1, 16'h0000, 1, exp, 0, 0, tag));
  endtask

  task automatic alu_run(input logic [15:0] instr, input logic [1:0] op,
                         input logic [15:0] exp, input string tag);
    ctl_t c = idle();
    put_ir(instr);
    c.gate = 4'b0100; c.op = op; c.s1s = 1; c.rg = 1; c.cc = 1;
    step(c, mk(1, exp, 0, 0, 0, 0, tag));
  endtask

  task automatic mar_set(input logic [15:0] a);
    ctl_t c = idle();
    c.gate = 4'b1000; c.adv = a; c.mar = 1;
    step(c, mk(1, a, 0, 0, 0, 0, "R3"));
  endtask

  task automatic mem_write();
    ctl_t c = idle();
    c.men = 1; c.mwe = 1;
    step(c, mk(1, 16'h0000, 0, 0, 0, 0, "R2"));
  endtask

  task automatic mdr_from_mem(input logic [15:0] busv);
    ctl_t c = idle();
    c.gate = 4'b0001; c.pcv = busv; c.mdr = 1; c.men = 1;
    step(c, mk(1, busv, 0, 0, 0, 0, "R10"));
  endtask

  task automatic show_mdr(input logic [15:0] exp, input string tag);
    ctl_t c = idle();
    c.gate = 4'b0010;
    step(c, mk(1, exp, 0, 0, 0, 0, tag));
  endtask

  initial begin
    ctl_t c;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 / R2: reset state and idle bus
    step(idle(), mk(1, 16'h0000, 1, 3'b010, 1, 16'h0000, "R1"));
    get_reg(3'd5, 16'h0000, "R1");

    // R3: each external source reaches the bus alone
    c = idle(); c.gate = 4'b0001; c.pcv = 16'hBEEF;
    step(c, mk(1, 16'hBEEF, 0, 0, 0, 0, "R3"));
    c = idle(); c.gate = 4'b1000; c.adv = 16'h0F0F;
    step(c, mk(1, 16'h0F0F, 0, 0, 0, 0, "R3"));
    peek_cc(3'b010, "R2");

    // R8: condition codes from bus values
    put_reg(3'd1, 16'h0005, 1);
    put_reg(3'd2, 16'hFFFD, 1);
    peek_cc(3'b100, "R8");
    put_reg(3'd3, 16'h0000, 1);
    peek_cc(3'b010, "R8");
    put_reg(3'd4, 16'h0040, 1);
    peek_cc(3'b001, "R8");
    put_reg(3'd5, 16'h8000, 0);
    peek_cc(3'b001, "R8");
    get_reg(3'd5, 16'h8000, "R4");

    // R4: no write without ld_reg
    put_ir({4'h1, 3'd1, 9'h0});
    c = idle(); c.gate = 4'b0001; c.pcv = 16'h7777;
    step(c, mk(1, 16'h7777, 0, 0, 0, 0, "R4"));
    get_reg(3'd1, 16'h0005, "R4");

    // R5: link register destination
    put_ir({4'h4, 3'd2, 9'h0});
    c = idle(); c.gate = 4'b0001; c.pcv = 16'h1357; c.rg = 1; c.drs = 1;
    step(c, mk(1, 16'h1357, 0, 0, 0, 0, "R5"));
    get_reg(3'd7, 16'h1357, "R5");
    get_reg(3'd2, 16'hFFFD, "R5");

    // R6: first source selection
    put_ir({4'h0, 3'd4, 3'd1, 6'd0});
    c = idle(); c.gate = 4'b0100; c.op = 2'b11; c.s1s = 0;
    step(c, mk(1, 16'h0040, 0, 0, 0, 0, "R6"));
    c.s1s = 1;
    step(c, mk(1, 16'h0005, 0, 0, 0, 0, "R6"));

    // R7: ALU operations, register and immediate operands
    alu_run({4'h1, 3'd6, 3'd1, 1'b0, 2'b00, 3'd2}, 2'b00, 16'h0002, "R7");
    peek_cc(3'b001, "R8");
    get_reg(3'd6, 16'h0002, "R7");
    alu_run({4'h1, 3'd6, 3'd1, 1'b1, 5'b10000}, 2'b00, 16'hFFF5, "R7");
    alu_run({4'h5, 3'd6, 3'd1, 1'b0, 2'b00, 3'd2}, 2'b01, 16'h0005, "R7");
    alu_run({4'h5, 3'd6, 3'd2, 1'b1, 5'b00011}, 2'b01, 16'h0001, "R7");
    alu_run({4'h9, 3'd6, 3'd1, 6'h3F}, 2'b10, 16'hFFFA, "R7");
    peek_cc(3'b100, "R8");

    // R9 / R10: memory store and load through MAR/MDR
    mar_set(16'h0021);
    c = idle(); c.gate = 4'b0001; c.pcv = 16'hA5C3; c.mdr = 1;
    step(c, mk(1, 16'hA5C3, 0, 0, 0, 0, "R10"));
    show_mdr(16'hA5C3, "R10");
    mem_write();
    mar_set(16'h0022);
    c = idle(); c.gate = 4'b0001; c.pcv = 16'h0F0F; c.mdr = 1;
    step(c, mk(1, 16'h0F0F, 0, 0, 0, 0, "R10"));
    mem_write();
    mar_set(16'h0021);
    mdr_from_mem(16'h1234);
    show_mdr(16'hA5C3, "R9");
    mar_set(16'h0022);
    mdr_from_mem(16'h4321);
    show_mdr(16'h0F0F, "R9");

    // R9: store a register via ALU pass, then load it back with CC
    put_ir({4'h3, 3'd4, 9'h0});
    c = idle(); c.gate = 4'b0100; c.op = 2'b11; c.mdr = 1;
    step(c, mk(1, 16'h0040, 0, 0, 0, 0, "R9"));
    mar_set(16'h0030);
    mem_write();
    mar_set(16'h0021);
    mdr_from_mem(16'h0000);
    mar_set(16'h0030);
    mdr_from_mem(16'h0000);
    put_ir({4'h2, 3'd3, 9'h0});
    c = idle(); c.gate = 4'b0010; c.rg = 1; c.cc = 1;
    step(c, mk(1, 16'h0040, 0, 0, 0, 0, "R9"));
    peek_cc(3'b001, "R8");
    get_reg(3'd3, 16'h0040, "R9");

    // R11: IR holds without ld_ir
    put_ir(16'h1111);
    c = idle(); c.gate = 4'b0001; c.pcv = 16'h2222;
    step(c, mk(1, 16'h2222, 0, 0, 1, 16'h1111, "R11"));
    step(idle(), mk(1, 16'h0000, 0, 0, 1, 16'h1111, "R11"));

    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, got hang expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule